// File: doc/BRIEF.md
# Reset and Interrupt Priority Resolver

This block looks at every reset cause and interrupt request that is active in the same cycle and names the single source that should be serviced next. The result is a registered source code with a valid flag. It stays frozen until the consumer pulses an acknowledge. Reset causes and two non-maskable exceptions form a fixed chain at the top. Below that chain sits a group of maskable sources. They follow a default order, but a software-written select field can lift any one of them above the others.

A small two-address write port holds the configuration: the promotion select code, the IRQ pin sense mode (level or falling edge), the oscillator start-up delay enable and the two clock-monitor enables. Reset loads defaults that make the IRQ pin the top maskable source, level-sensitive, with the start-up delay on and the clock monitor off. The IRQ pin feeds a fixed slot of the maskable vector. In edge mode it passes through a pending latch that the IRQ acknowledge clears.

Top module: `irq_prio_resolver`

## Requirements
- R1: While reset is applied and just after it, `src_valid` is 0, `osc_dly_en` is 1 and `clkmon_en` is 0.
- R2: Codes are 0 power-on/pin reset, 1 clock-monitor reset, 2 watchdog reset, 3 XIRQ, 4 illegal opcode, and 5+i for maskable source i. Among simultaneous requests the winner follows that order from 0 to 4, and every fixed source beats every maskable one.
- R3: A clock-monitor request is ignored while `clkmon_en` is 0. `clkmon_en` is the OR of option bit 2 and option bit 3.
- R4: XIRQ is blocked only by `x_mask`, never by `i_mask`. The illegal-opcode trap is blocked by neither.
- R5: While `i_mask` is 1, no maskable source wins, including the promoted one.
- R6: Maskable sources that are not promoted win by ascending index. If the select code matches no requesting source, or is at least `N_MASK`, the ascending order applies to all maskable sources.
- R7: A write to address 0 stores `wr_data[4:0]` as the select code, and the source with that index beats all other maskable sources. The reset value is 6, the IRQ pin slot, so IRQ (code 11) beats source 0.
- R8: After reset the IRQ pin is level-sensitive (option bit 0 = 0). A low `irq_n` requests slot 6 for as long as it stays low.
- R9: With option bit 0 = 1, a falling edge on `irq_n` sets a pending request that survives the pin going high. Acknowledging code 11 clears it.
- R10: The source code is loaded only while `src_valid` is 0. It then holds until a cycle with `ack` = 1. That cycle clears `src_valid`, and the next cycle evaluates the requests again.
- R11: Bit 6 of `mreq` is ORed with the IRQ pin request and wins as code 11 in either sense mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_req | input | 1 | Power-on or reset-pin cause |
| clkmon_req | input | 1 | Clock-monitor failure cause |
| cop_req | input | 1 | Watchdog timeout cause |
| xirq_req | input | 1 | Non-maskable XIRQ request |
| illop_req | input | 1 | Illegal-opcode trap request |
| x_mask | input | 1 | X mask bit of the condition codes |
| i_mask | input | 1 | I mask bit of the condition codes |
| mreq | input | 16 | Maskable request vector |
| irq_n | input | 1 | External IRQ pin, active low |
| ack | input | 1 | Acknowledge of the presented source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = select code, 1 = option bits |
| wr_data | input | 5 | Write data |
| src_valid | output | 1 | A source code is presented |
| src_code | output | 5 | Winning source code |
| osc_dly_en | output | 1 | Oscillator start-up delay enable (option bit 1) |
| clkmon_en | output | 1 | Clock monitor enabled |

## Verification
The hardest situation to reach is an edge-mode IRQ that is still pending after the pin has gone high, while the output register holds another source. The latch must survive until its own acknowledge and no longer. The stimulus switches the mode through the write port, pulses the pin low for one cycle and lets the pending request win. It then acknowledges that request and checks that an idle pin produces no second request. A separate hold scenario raises a reset cause under an unacknowledged maskable winner, to show the output stays frozen until the acknowledge.

// File: rtl/irqpr_pkg.sv
package irqpr_pkg;
  localparam int unsigned FIX_N      = 5;
  localparam int unsigned CODE_RST   = 0;
  localparam int unsigned CODE_CMON  = 1;
  localparam int unsigned CODE_COP   = 2;
  localparam int unsigned CODE_XIRQ  = 3;
  localparam int unsigned CODE_ILLOP = 4;

  typedef struct packed {
    logic edge_mode;
    logic dly;
    logic cme;
    logic fcme;
  } opt_t;
endpackage

// File: rtl/irqpr_rst_sync.sv
module irqpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/irqpr_cfg_regs.sv
module irqpr_cfg_regs
  import irqpr_pkg::*;
#(
  parameter int unsigned SEL_W    = 5,
  parameter int unsigned SEL_RST  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [SEL_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_o,
  output opt_t             opt_o
);
  logic [SEL_W-1:0] sel_q, sel_d;
  opt_t             opt_q, opt_d;
  logic             sel_we, opt_we;

  assign sel_we = wr_en && !wr_addr;
  assign opt_we = wr_en &&  wr_addr;

  always_comb begin
    sel_d = sel_q;
    opt_d = opt_q;
    if (sel_we) sel_d = wr_data;
    if (opt_we) begin
      opt_d.edge_mode = wr_data[0];
      opt_d.dly       = wr_data[1];
      opt_d.cme       = wr_data[2];
      opt_d.fcme      = wr_data[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_W'(SEL_RST);
      opt_q <= '{edge_mode: 1'b0, dly: 1'b1, cme: 1'b0, fcme: 1'b0};
    end else if (sel_we || opt_we) begin
      sel_q <= sel_d;
      opt_q <= opt_d;
    end
  end

  assign sel_o = sel_q;
  assign opt_o = opt_q;
endmodule

// File: rtl/irqpr_irq_sense.sv
module irqpr_irq_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic edge_mode,
  input  logic irq_ack,
  output logic irq_req
);
  logic pin_q;
  logic pend_q, pend_d;
  logic fall;

  assign fall = pin_q && !irq_n;

  always_comb begin
    pend_d = pend_q;
    if (!edge_mode)       pend_d = 1'b0;
    else if (fall)        pend_d = 1'b1;
    else if (irq_ack)     pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      pin_q  <= irq_n;
      pend_q <= pend_d;
    end
  end

  assign irq_req = edge_mode ? pend_q : !irq_n;
endmodule

// File: rtl/irqpr_mask_arb.sv
module irqpr_mask_arb #(
  parameter int unsigned N     = 16,
  parameter int unsigned SEL_W = 5,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic             prom_hit;
  logic [IDX_W-1:0] prom_idx;
  logic             dflt_hit;
  logic [IDX_W-1:0] dflt_idx;

  always_comb begin
    prom_hit = 1'b0;
    prom_idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      if ((SEL_W'(i) == sel) && req[i]) begin
        prom_hit = 1'b1;
        prom_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    dflt_hit = 1'b0;
    dflt_idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req[i]) begin
        dflt_hit = 1'b1;
        dflt_idx = IDX_W'(i);
      end
    end
  end

  assign hit = prom_hit || dflt_hit;
  assign idx = prom_hit ? prom_idx : dflt_idx;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irqpr_pkg::*;
#(
  parameter int unsigned N_MASK  = 16,
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned IRQ_IDX = 6,
  localparam int unsigned IDX_W  = $clog2(N_MASK),
  localparam int unsigned SRC_W  = $clog2(FIX_N + N_MASK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_req,
  input  logic              clkmon_req,
  input  logic              cop_req,
  input  logic              xirq_req,
  input  logic              illop_req,
  input  logic              x_mask,
  input  logic              i_mask,
  input  logic [N_MASK-1:0] mreq,
  input  logic              irq_n,
  input  logic              ack,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [SEL_W-1:0]  wr_data,
  output logic              src_valid,
  output logic [SRC_W-1:0]  src_code,
  output logic              osc_dly_en,
  output logic              clkmon_en
);
  localparam logic [SRC_W-1:0] IRQ_CODE = SRC_W'(FIX_N + IRQ_IDX);

  logic              rst_sync_n;
  logic [SEL_W-1:0]  sel;
  opt_t              opt;
  logic              irq_req, irq_ack;
  logic [N_MASK-1:0] mreq_eff, mreq_elig;
  logic              m_hit;
  logic [IDX_W-1:0]  m_idx;
  logic              win_v;
  logic [SRC_W-1:0]  win_code;
  logic              valid_q, valid_d;
  logic [SRC_W-1:0]  code_q, code_d;
  logic              out_en;

  irqpr_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irqpr_cfg_regs #(.SEL_W(SEL_W), .SEL_RST(IRQ_IDX)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_o(sel), .opt_o(opt)
  );

  irqpr_irq_sense u_sense (
    .clk(clk), .rst_n(rst_sync_n), .irq_n(irq_n),
    .edge_mode(opt.edge_mode), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // IRQ pin shares its slot with the vector bit (wired-OR)
  for (genvar g = 0; g < int'(N_MASK); g++) begin : g_slot
    if (g == int'(IRQ_IDX)) begin : g_irq
      assign mreq_eff[g] = mreq[g] || irq_req;
    end else begin : g_plain
      assign mreq_eff[g] = mreq[g];
    end
  end

  assign mreq_elig = i_mask ? '0 : mreq_eff;

  irqpr_mask_arb #(.N(N_MASK), .SEL_W(SEL_W)) u_marb (
    .req(mreq_elig), .sel(sel), .hit(m_hit), .idx(m_idx)
  );

  assign clkmon_en  = opt.cme || opt.fcme;
  assign osc_dly_en = opt.dly;

  // Fixed chain ahead of the maskable group
  always_comb begin
    win_v    = 1'b1;
    win_code = '0;
    if (por_req)                      win_code = SRC_W'(CODE_RST);
    else if (clkmon_req && clkmon_en) win_code = SRC_W'(CODE_CMON);
    else if (cop_req)                 win_code = SRC_W'(CODE_COP);
    else if (xirq_req && !x_mask)     win_code = SRC_W'(CODE_XIRQ);
    else if (illop_req)               win_code = SRC_W'(CODE_ILLOP);
    else if (m_hit)                   win_code = SRC_W'(FIX_N) + SRC_W'(m_idx);
    else                              win_v    = 1'b0;
  end

  assign irq_ack = valid_q && ack && (code_q == IRQ_CODE);
  assign out_en  = valid_q ? ack : win_v;

  always_comb begin
    valid_d = valid_q;
    code_d  = code_q;
    if (valid_q) begin
      valid_d = 1'b0;
    end else begin
      valid_d = 1'b1;
      code_d  = win_code;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (out_en) begin
      valid_q <= valid_d;
      code_q  <= code_d;
    end
  end

  assign src_valid = valid_q;
  assign src_code  = code_q;
endmodule

// File: rtl/irqpr_checker.sv
module irqpr_checker #(
  parameter int unsigned SRC_W  = 5,
  parameter int unsigned N_MASK = 16,
  parameter int unsigned FIX_N  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_valid,
  input logic [SRC_W-1:0] src_code,
  input logic             ack,
  input logic             por_req,
  input logic             i_mask,
  input logic             clkmon_en
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !ack) |=> (src_valid && $stable(src_code))); // R10
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && ack) |=> !src_valid); // R10
  AST_RESET_CAUSE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_valid && por_req) |=> (src_valid && src_code == '0)); // R2
  AST_IMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_valid && i_mask) |=> (!src_valid || src_code < SRC_W'(FIX_N))); // R5
  AST_CLKMON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_valid && !clkmon_en) |=> !(src_valid && src_code == SRC_W'(1))); // R3
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |-> (int'(src_code) < int'(FIX_N + N_MASK))); // R2
endmodule

bind irq_prio_resolver irqpr_checker #(
  .SRC_W(SRC_W), .N_MASK(N_MASK), .FIX_N(irqpr_pkg::FIX_N)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .src_valid(src_valid), .src_code(src_code),
  .ack(ack), .por_req(por_req), .i_mask(i_mask), .clkmon_en(clkmon_en)
);

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        por_req, clkmon_req, cop_req, xirq_req, illop_req;
  logic        x_mask, i_mask;
  logic [15:0] mreq;
  logic        irq_n, ack, wr_en, wr_addr;
  logic [4:0]  wr_data;
  logic        src_valid;
  logic [4:0]  src_code;
  logic        osc_dly_en, clkmon_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  irq_prio_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .por_req(por_req), .clkmon_req(clkmon_req),
    .cop_req(cop_req), .xirq_req(xirq_req), .illop_req(illop_req),
    .x_mask(x_mask), .i_mask(i_mask), .mreq(mreq), .irq_n(irq_n), .ack(ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_valid(src_valid), .src_code(src_code),
    .osc_dly_en(osc_dly_en), .clkmon_en(clkmon_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    por_req = 0; clkmon_req = 0; cop_req = 0; xirq_req = 0; illop_req = 0;
    x_mask = 0; i_mask = 0; mreq = '0; irq_n = 1; ack = 0;
  endtask

  task automatic write_reg(input logic a, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // Present requests for one evaluation, check, then acknowledge and clear
  task automatic arb(input string req, input logic [4:0] fixed,
                     input logic xm, input logic im, input logic [15:0] mv,
                     input logic irqn, input int exp_v, input int exp_c);
    @(negedge clk);
    {por_req, clkmon_req, cop_req, xirq_req, illop_req} = fixed;
    x_mask = xm; i_mask = im; mreq = mv; irq_n = irqn;
    @(negedge clk);
    chk(req, int'(src_valid), exp_v);
    if (exp_v == 1) chk(req, int'(src_code), exp_c);
    idle();
    ack = 1;
    @(negedge clk);
    ack = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0;
    #35;
    chk("R1", int'(src_valid), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", int'(src_valid), 0);
    chk("R1", int'(osc_dly_en), 1);
    chk("R1", int'(clkmon_en), 0);
  endtask

  task automatic t_fixed_chain();
    arb("R2", 5'b10111, 0, 0, 16'h0003, 1, 1, 0);
    arb("R2", 5'b00111, 0, 0, 16'h0003, 1, 1, 2);
    arb("R2", 5'b00011, 0, 0, 16'h0003, 0, 1, 3);
    arb("R2", 5'b00001, 0, 0, 16'hFFFF, 0, 1, 4);
  endtask

  task automatic t_clkmon();
    arb("R3", 5'b01100, 0, 0, 16'h0, 1, 1, 2);
    write_reg(1'b1, 5'b00110);
    chk("R3", int'(clkmon_en), 1);
    arb("R3", 5'b01100, 0, 0, 16'h0, 1, 1, 1);
    write_reg(1'b1, 5'b01010);
    arb("R3", 5'b01100, 0, 0, 16'h0, 1, 1, 1);
    write_reg(1'b1, 5'b00010);
    chk("R3", int'(clkmon_en), 0);
  endtask

  task automatic t_masks();
    arb("R4", 5'b00010, 1, 0, 16'h0002, 1, 1, 6);
    arb("R4", 5'b00010, 0, 1, 16'h0002, 1, 1, 3);
    arb("R4", 5'b00001, 1, 1, 16'h0002, 1, 1, 4);
    arb("R5", 5'b00000, 0, 1, 16'hFFFF, 0, 0, 0);
  endtask

  task automatic t_select();
    arb("R7", 5'b00000, 0, 0, 16'h0001, 0, 1, 11);
    arb("R8", 5'b00000, 0, 0, 16'h0000, 0, 1, 11);
    write_reg(1'b0, 5'd9);
    arb("R7", 5'b00000, 0, 0, 16'h0208, 1, 1, 14);
    arb("R6", 5'b00000, 0, 0, 16'h0024, 1, 1, 7);
    write_reg(1'b0, 5'd31);
    arb("R6", 5'b00000, 0, 0, 16'h0208, 1, 1, 8);
    arb("R6", 5'b00000, 0, 0, 16'h0008, 0, 1, 8);
    write_reg(1'b0, 5'd6);
    arb("R11", 5'b00000, 0, 0, 16'h0040, 1, 1, 11);
    arb("R11", 5'b00000, 0, 0, 16'h0000, 1, 0, 0);
  endtask

  task automatic t_edge();
    write_reg(1'b1, 5'b00011);
    @(negedge clk); irq_n = 0;
    @(negedge clk); irq_n = 1;
    @(negedge clk);
    chk("R9", int'(src_valid), 1);
    chk("R9", int'(src_code), 11);
    ack = 1;
    @(negedge clk); ack = 0;
    @(negedge clk);
    chk("R9", int'(src_valid), 0);
    arb("R11", 5'b00000, 0, 0, 16'h0040, 1, 1, 11);
    write_reg(1'b1, 5'b00010);
  endtask

  task automatic t_hold();
    @(negedge clk); mreq = 16'h0004;
    @(negedge clk); mreq = '0; por_req = 1;
    chk("R10", int'(src_code), 7);
    repeat (2) @(negedge clk);
    chk("R10", int'(src_valid), 1);
    chk("R10", int'(src_code), 7);
    ack = 1;
    @(negedge clk); ack = 0;
    chk("R10", int'(src_valid), 0);
    @(negedge clk);
    chk("R10", int'(src_code), 0);
    idle(); ack = 1;
    @(negedge clk); ack = 0;
    @(negedge clk);
  endtask

  initial begin
    idle();
    wr_en = 0; wr_addr = 0; wr_data = '0;
    t_reset();
    t_fixed_chain();
    t_clkmon();
    t_masks();
    t_select();
    t_edge();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule